// File: doc/BRIEF.md
# Push-pull two-wire serial engine

This block is the bit-level master of a point-to-point serial link made of one clock line and one data line, both driven push-pull. There is only one target on the link, so a frame never carries a device address. A frame opens with a start condition and sends one register-address byte. After that it either sends data bytes for a write, or hands the data line to the target, which returns the data bytes of a read in the same frame. Every 8-bit group is followed by an even-parity bit. No acknowledge slot exists. A stop condition closes the frame.

A register front end drives the block. It presents the register address, a byte count, the direction, up to eight write bytes, a clock divider and a data-output delay, and then pulses the start input. The engine latches all of these when it accepts the pulse. At the end of the frame it pulses done and holds the error flag and the received bytes until the next frame begins.

Top module: `pp2w_master`

## Requirements
- R1: After reset, and whenever no frame is in progress, scl_o, sda_o and sda_oe_o are 1 and busy_o, done_o and err_o are 0. A reset in the middle of a frame returns all of them to these values at once, and rdata_o to zero.
- R2: A frame begins with sda_o falling while scl_o is high. It ends with the line rising while scl_o is high, after which scl_o and sda_o stay high.
- R3: Bits are sent MSB first. The frame carries the address byte, then len_i+1 data bytes (len_i = 0 means one byte, 7 means eight). Each byte is followed by one parity bit equal to the XOR of its 8 bits, and there is no acknowledge bit. This gives 9*(len_i+2) clock pulses. One further pulse with the line low then precedes the stop.
- R4: While busy, every level of scl_o, including the first high level after the start, lasts exactly div_i+1 clock cycles.
- R5: While scl_o is low, any change of sda_o takes place exactly dly_i clock cycles after the falling edge of scl_o. The input must satisfy dly_i <= div_i.
- R6: On a read (rd_i = 1), sda_oe_o goes low after the address parity bit and stays low through the last data parity bit. Target bits are sampled as scl_o rises. Received byte j (counting from 0) appears at rdata_o[8j+7:8j], and the bytes beyond the length read as zero. On a write, rdata_o is all zero.
- R7: err_o is 1 after a read in which any received parity bit differs from the XOR of its byte. After any write it is 0.
- R8: done_o is a single-cycle pulse. In that cycle busy_o has just fallen.
- R9: A start_i pulse while busy is ignored. Changes of any configuration input after the start is accepted do not affect the frame in progress.
- R10: During the bit phase, sda_o changes only while scl_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | module clock |
| rst_n | input | 1 | asynchronous active-low reset |
| start_i | input | 1 | one-cycle request to begin a frame |
| reg_addr_i | input | 8 | register address byte |
| len_i | input | 3 | number of data bytes minus one |
| rd_i | input | 1 | 1 = read, 0 = write |
| wdata_i | input | 64 | write bytes, byte j at bits 8j+7:8j |
| div_i | input | 8 | half-period of scl_o minus one, in clock cycles |
| dly_i | input | 3 | delay of sda_o changes after the falling scl_o edge |
| sda_i | input | 1 | data line as seen from the target |
| scl_o | output | 1 | serial clock |
| sda_o | output | 1 | data line drive value |
| sda_oe_o | output | 1 | data line drive enable (0 = released to the target) |
| busy_o | output | 1 | frame in progress |
| done_o | output | 1 | one-cycle pulse at frame end |
| err_o | output | 1 | received parity mismatch in the last frame |
| rdata_o | output | 64 | received bytes of the last read |

## Verification
The timing assertions assume that the front end never asks for an output delay longer than a half period (dly_i <= div_i). They also assume that the target changes its data only while the clock is low. The bench keeps to both. Every table row and directed test uses a delay no larger than its divider. The modelled target updates sda_i in the sample that follows each falling clock edge and never at any other time.

// File: rtl/pp2w_pkg.sv
package pp2w_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_STOP_LO,
    ST_STOP_HI,
    ST_STOP_END
  } pp2w_state_e;

  // even parity: the bit that makes the number of ones in nine bits even
  function automatic logic even_par(input logic [7:0] b);
    return ^b;
  endfunction

  // bit k of a 9-bit group, MSB first, parity in slot 8
  function automatic logic group_bit(input logic [7:0] b, input logic [3:0] k);
    if (k >= 4'd8) return even_par(b);
    return b[3'(4'd7 - k)];
  endfunction

endpackage

// File: rtl/pp2w_halfclk.sv
module pp2w_halfclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pp2w_sda_dly.sv
module pp2w_sda_dly #(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_sda,
  input  logic             req_oe,
  input  logic [DLY_W-1:0] dly,
  output logic             sda,
  output logic             oe
);
  logic             pend_sda, pend_oe, pending;
  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda      <= 1'b1;
      oe       <= 1'b1;
      pend_sda <= 1'b1;
      pend_oe  <= 1'b1;
      pending  <= 1'b0;
      cnt      <= '0;
    end else if (req) begin
      if (dly == '0) begin
        sda     <= req_sda;
        oe      <= req_oe;
        pending <= 1'b0;
      end else begin
        pend_sda <= req_sda;
        pend_oe  <= req_oe;
        cnt      <= dly;
        pending  <= 1'b1;
      end
    end else if (pending) begin
      if (cnt == DLY_W'(1)) begin
        sda     <= pend_sda;
        oe      <= pend_oe;
        pending <= 1'b0;
      end
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/pp2w_seq.sv
module pp2w_seq
  import pp2w_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int DIV_W     = 8,
  parameter int DLY_W     = 3,
  localparam int LEN_W    = $clog2(MAX_BYTES),
  localparam int IDX_W    = $clog2(MAX_BYTES + 1),
  localparam int DAT_W    = 8 * MAX_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       addr_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             rd_i,
  input  logic [DAT_W-1:0] wdata_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             tick,
  input  logic             sda_in,
  output logic             busy,
  output logic             scl,
  output logic             req,
  output logic             req_sda,
  output logic             req_oe,
  output logic [DIV_W-1:0] div_use,
  output logic [DLY_W-1:0] dly_use,
  output logic             done,
  output logic             err,
  output logic [DAT_W-1:0] rdata,
  output logic             rd_mode,
  output logic             bits_phase
);
  pp2w_state_e      st;
  logic [7:0]       addr_q;
  logic [LEN_W-1:0] len_q;
  logic             rd_q;
  logic [DAT_W-1:0] wdata_q;
  logic [DIV_W-1:0] div_q;
  logic [DLY_W-1:0] dly_q;
  logic [IDX_W-1:0] byte_idx, nxt_byte, last_byte;
  logic [3:0]       bit_idx, nxt_bit;
  logic [7:0]       rx_sh, nxt_val;
  logic             err_q, done_q, scl_q;
  logic [DAT_W-1:0] rdata_q;
  logic             last_bit, grp_end;

  assign last_byte = IDX_W'(len_q) + IDX_W'(1);
  assign grp_end   = (bit_idx == 4'd8);
  assign last_bit  = grp_end && (byte_idx == last_byte);
  assign nxt_bit   = grp_end ? 4'd0 : bit_idx + 4'd1;
  assign nxt_byte  = grp_end ? byte_idx + IDX_W'(1) : byte_idx;

  // byte carried by the group that follows the current bit
  always_comb begin
    nxt_val = addr_q;
    for (int j = 0; j < MAX_BYTES; j++)
      if (nxt_byte == IDX_W'(j + 1)) nxt_val = wdata_q[8*j +: 8];
  end

  // requests to the delayed data-line driver
  always_comb begin
    req     = 1'b0;
    req_sda = 1'b1;
    req_oe  = 1'b1;
    case (st)
      ST_IDLE: if (start) begin
        req     = 1'b1;
        req_sda = 1'b0;
      end
      ST_START: if (tick) begin
        req     = 1'b1;
        req_sda = group_bit(addr_q, 4'd0);
      end
      ST_BIT_HI: if (tick) begin
        req = 1'b1;
        if (last_bit) begin
          req_sda = 1'b0;
        end else if (rd_q && nxt_byte != '0) begin
          req_sda = 1'b1;
          req_oe  = 1'b0;
        end else begin
          req_sda = group_bit(nxt_val, nxt_bit);
        end
      end
      ST_STOP_HI: if (tick) begin
        req     = 1'b1;
        req_sda = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      addr_q   <= '0;
      len_q    <= '0;
      rd_q     <= 1'b0;
      wdata_q  <= '0;
      div_q    <= '0;
      dly_q    <= '0;
      byte_idx <= '0;
      bit_idx  <= '0;
      rx_sh    <= '0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
      scl_q    <= 1'b1;
      rdata_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          addr_q   <= addr_i;
          len_q    <= len_i;
          rd_q     <= rd_i;
          wdata_q  <= wdata_i;
          div_q    <= div_i;
          dly_q    <= dly_i;
          byte_idx <= '0;
          bit_idx  <= '0;
          err_q    <= 1'b0;
          rdata_q  <= '0;
          st       <= ST_START;
        end
        ST_START: if (tick) begin
          scl_q <= 1'b0;
          st    <= ST_BIT_LO;
        end
        ST_BIT_LO: if (tick) begin
          scl_q <= 1'b1;
          st    <= ST_BIT_HI;
          if (rd_q && byte_idx != '0) begin
            if (!grp_end) begin
              rx_sh <= {rx_sh[6:0], sda_in};
            end else begin
              if (even_par(rx_sh) != sda_in) err_q <= 1'b1;
              for (int j = 0; j < MAX_BYTES; j++)
                if (byte_idx == IDX_W'(j + 1)) rdata_q[8*j +: 8] <= rx_sh;
            end
          end
        end
        ST_BIT_HI: if (tick) begin
          scl_q <= 1'b0;
          if (last_bit) begin
            st <= ST_STOP_LO;
          end else begin
            bit_idx  <= nxt_bit;
            byte_idx <= nxt_byte;
            st       <= ST_BIT_LO;
          end
        end
        ST_STOP_LO: if (tick) begin
          scl_q <= 1'b1;
          st    <= ST_STOP_HI;
        end
        ST_STOP_HI: if (tick) st <= ST_STOP_END;
        ST_STOP_END: if (tick) begin
          done_q <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (st != ST_IDLE);
  assign scl        = scl_q;
  assign div_use    = div_q;
  assign dly_use    = (st == ST_IDLE) ? dly_i : dly_q;
  assign done       = done_q;
  assign err        = err_q;
  assign rdata      = rdata_q;
  assign rd_mode    = rd_q;
  assign bits_phase = (st == ST_BIT_LO) || (st == ST_BIT_HI) || (st == ST_STOP_LO);
endmodule

// File: rtl/pp2w_master.sv
module pp2w_master #(
  parameter int MAX_BYTES = 8,
  parameter int DIV_W     = 8,
  parameter int DLY_W     = 3,
  localparam int LEN_W    = $clog2(MAX_BYTES),
  localparam int DAT_W    = 8 * MAX_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [7:0]       reg_addr_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             rd_i,
  input  logic [DAT_W-1:0] wdata_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             sda_i,
  output logic             scl_o,
  output logic             sda_o,
  output logic             sda_oe_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [DAT_W-1:0] rdata_o
);
  // named internal events, also observed by the bound checker
  logic             tick_w;
  logic             busy_w;
  logic             req_w, req_sda_w, req_oe_w;
  logic             rd_q_w;
  logic             bits_phase_w;
  logic [DIV_W-1:0] div_q_w;
  logic [DLY_W-1:0] dly_use_w;

  pp2w_halfclk #(.DIV_W(DIV_W)) u_half (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy_w),
    .div  (div_q_w),
    .tick (tick_w)
  );

  pp2w_seq #(
    .MAX_BYTES(MAX_BYTES),
    .DIV_W    (DIV_W),
    .DLY_W    (DLY_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_i),
    .addr_i    (reg_addr_i),
    .len_i     (len_i),
    .rd_i      (rd_i),
    .wdata_i   (wdata_i),
    .div_i     (div_i),
    .dly_i     (dly_i),
    .tick      (tick_w),
    .sda_in    (sda_i),
    .busy      (busy_w),
    .scl       (scl_o),
    .req       (req_w),
    .req_sda   (req_sda_w),
    .req_oe    (req_oe_w),
    .div_use   (div_q_w),
    .dly_use   (dly_use_w),
    .done      (done_o),
    .err       (err_o),
    .rdata     (rdata_o),
    .rd_mode   (rd_q_w),
    .bits_phase(bits_phase_w)
  );

  pp2w_sda_dly #(.DLY_W(DLY_W)) u_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req_w),
    .req_sda(req_sda_w),
    .req_oe (req_oe_w),
    .dly    (dly_use_w),
    .sda    (sda_o),
    .oe     (sda_oe_o)
  );

  assign busy_o = busy_w;
endmodule

// File: rtl/pp2w_master_chk.sv
module pp2w_master_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_o,
  input logic             sda_o,
  input logic             sda_oe_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic             rd_q,
  input logic             bits_phase,
  input logic [DIV_W-1:0] div_q
);
  logic [DIV_W:0] since;
  logic           scl_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since    <= '0;
      scl_prev <= 1'b1;
    end else begin
      scl_prev <= scl_o;
      if (!busy_o)               since <= '0;
      else if (scl_o != scl_prev) since <= (DIV_W+1)'(1);
      else                       since <= since + 1'b1;
    end
  end

  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (scl_o && sda_o && sda_oe_o));

  p_half_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && scl_o != scl_prev) |-> (since == {1'b0, div_q} + 1'b1));

  p_release_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sda_oe_o |-> (busy_o && rd_q));

  p_write_no_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !rd_q) |-> !err_o);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  p_data_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bits_phase && !$stable(sda_o)) |-> !scl_o);
endmodule

bind pp2w_master pp2w_master_chk #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_o     (scl_o),
  .sda_o     (sda_o),
  .sda_oe_o  (sda_oe_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .rd_q      (rd_q_w),
  .bits_phase(bits_phase_w),
  .div_q     (div_q_w)
);

// File: tb/pp2w_master_test.sv
module pp2w_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [2:0]  len_i = '0;
  logic        rd_i = 1'b0;
  logic [63:0] wdata_i = '0;
  logic [7:0]  div_i = '0;
  logic [2:0]  dly_i = '0;
  logic        sda_i = 1'b1;
  logic        scl_o, sda_o, sda_oe_o, busy_o, done_o, err_o;
  logic [63:0] rdata_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pp2w_master uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .reg_addr_i(reg_addr_i),
    .len_i(len_i), .rd_i(rd_i), .wdata_i(wdata_i), .div_i(div_i), .dly_i(dly_i),
    .sda_i(sda_i), .scl_o(scl_o), .sda_o(sda_o), .sda_oe_o(sda_oe_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o)
  );

  // {addr, bytes, read, bad-parity mask, divider, delay, data}
  localparam logic [111:0] VECS [8] = '{
    {8'hA5, 8'd1, 8'd0, 8'h00, 8'd1, 8'd0, 64'h0000_0000_0000_003C},
    {8'h0F, 8'd2, 8'd0, 8'h00, 8'd3, 8'd2, 64'h0000_0000_0000_1234},
    {8'h00, 8'd8, 8'd1, 8'h80, 8'd4, 8'd3, 64'hFEDC_BA98_7654_3210},
    {8'h3E, 8'd1, 8'd1, 8'h00, 8'd2, 8'd1, 64'h0000_0000_0000_005A},
    {8'h71, 8'd4, 8'd1, 8'h00, 8'd5, 8'd5, 64'h0000_0000_DEAD_BEEF},
    {8'hC3, 8'd3, 8'd1, 8'h02, 8'd1, 8'd1, 64'h0000_0000_0000_AA55},
    {8'h80, 8'd8, 8'd0, 8'h00, 8'd0, 8'd0, 64'h0123_4567_89AB_CDEF},
    {8'hFF, 8'd5, 8'd0, 8'h00, 8'd7, 8'd7, 64'h0000_00FF_FF00_FF00}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_xfer(input logic [7:0] a, input int nb, input logic rd,
                          input logic [7:0] bad, input logic [7:0] dv,
                          input logic [2:0] dl, input logic [63:0] dat,
                          input bit poke);
    logic [81:0] exp_bits, got_bits;
    logic [7:0]  by;
    logic [63:0] exp_rd;
    logic        scl, line, p_scl, p_line, p_sda, exp_err, exp_oe, poked;
    int exp_n, nbits, since, sfall, hp_bad, dl_bad, oe_bad, bit_bad;
    int ndone, done_busy, after, cyc;
    bit started, stopped, pre_bits;

    exp_bits = '0; got_bits = '0; exp_rd = '0;
    exp_n = 9 * (nb + 1);
    for (int i = 0; i <= nb; i++) begin
      by = (i == 0) ? a : dat[8*(i-1) +: 8];
      for (int k = 0; k < 8; k++) exp_bits[9*i + k] = by[7-k];
      exp_bits[9*i + 8] = (^by) ^ ((rd && i > 0) ? bad[i-1] : 1'b0);
      if (rd && i > 0) exp_rd[8*(i-1) +: 8] = by;
    end
    exp_bits[exp_n] = 1'b0;  // stop-preceding pulse
    exp_err = rd && ((9'(bad) & ((9'd1 << nb) - 9'd1)) != 9'd0);

    @(negedge clk);
    reg_addr_i = a; len_i = 3'(nb - 1); rd_i = rd;
    wdata_i = rd ? 64'h0 : dat; div_i = dv; dly_i = dl; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;  // R9: scramble configuration while busy
    reg_addr_i = ~a; len_i = ~len_i; rd_i = ~rd; wdata_i = ~wdata_i;
    div_i = dv + 8'd3; dly_i = ~dl;

    p_scl = 1'b1; p_line = 1'b1; p_sda = 1'b1; poked = 1'b0;
    nbits = 0; since = -1; sfall = 0; hp_bad = 0; dl_bad = 0; oe_bad = 0;
    ndone = 0; done_busy = 0; after = -1; cyc = 0;
    started = 0; stopped = 0; pre_bits = 0;

    while (cyc < 20000 && after != 0) begin
      scl  = scl_o;
      line = sda_oe_o ? sda_o : sda_i;
      start_i = 1'b0;
      since++;
      sfall++;
      if (scl != p_scl) begin
        if (busy_o && since != int'(dv) + 1) hp_bad++;
        since = 0;
        if (!scl) begin
          sfall = 0;
          if (rd && nbits >= 9 && nbits < exp_n) sda_i = exp_bits[nbits];
          else sda_i = 1'b1;
        end
      end
      if (!scl && sda_o != p_sda && sfall != int'(dl)) dl_bad++;
      if (scl && p_scl && p_line && !line) begin
        started = 1;
        if (nbits != 0) pre_bits = 1;
      end
      if (scl && !p_scl) begin
        if (!started) pre_bits = 1;
        if (nbits < 82) got_bits[nbits] = line;
        exp_oe = !(rd && nbits >= 9 && nbits < exp_n);
        if (sda_oe_o != exp_oe) oe_bad++;
        nbits++;
      end
      if (scl && p_scl && !p_line && line) stopped = 1;
      if (poke && nbits == 5 && !poked) begin
        start_i = 1'b1;
        reg_addr_i = 8'h5A;
        poked = 1'b1;
      end
      if (done_o) begin
        ndone++;
        if (busy_o) done_busy++;
        if (after < 0) after = 4;
      end
      if (after > 0) after--;
      p_scl = scl; p_line = line; p_sda = sda_o;
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    sda_i = 1'b1;

    bit_bad = 0;
    for (int i = 0; i <= exp_n; i++) if (got_bits[i] != exp_bits[i]) bit_bad++;

    chk(cyc < 20000, "R8", "transfer finished", 64'(cyc), 64'd20000);
    chk(started && stopped && !pre_bits, "R2", "start and stop conditions",
        {62'd0, started, stopped}, 64'd3);
    chk(nbits == exp_n + 1, "R3", "clock pulse count", 64'(nbits), 64'(exp_n + 1));
    chk(bit_bad == 0, "R3", "frame bits", got_bits[63:0], exp_bits[63:0]);
    chk(hp_bad == 0, "R4", "half-period mismatches", 64'(hp_bad), 64'd0);
    chk(dl_bad == 0, "R5", "sda delay mismatches", 64'(dl_bad), 64'd0);
    chk(oe_bad == 0, "R6", "drive enable mismatches", 64'(oe_bad), 64'd0);
    chk(rdata_o == exp_rd, "R6", "received data", rdata_o, exp_rd);
    chk(err_o == exp_err, "R7", "parity error flag", 64'(err_o), 64'(exp_err));
    chk(ndone == 1 && done_busy == 0, "R8", "single done pulse while idle",
        64'(ndone), 64'd1);
    if (poke)
      chk(ndone == 1 && bit_bad == 0 && !busy_o, "R9", "start while busy ignored",
          64'(ndone), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(scl_o && sda_o && sda_oe_o, "R1", "lines in reset",
        {61'd0, scl_o, sda_o, sda_oe_o}, 64'd7);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !done_o && !err_o && rdata_o == '0, "R1", "flags after reset",
        {61'd0, busy_o, done_o, err_o}, 64'd0);

    for (int i = 0; i < 8; i++) begin
      logic [111:0] v;
      v = VECS[i];
      run_xfer(v[111:104], int'(v[103:96]), v[88], v[87:80], v[79:72], v[66:64],
               v[63:0], (i % 4) == 1);
      chk(scl_o && sda_o && sda_oe_o && !busy_o, "R1", "idle after frame",
          {60'd0, scl_o, sda_o, sda_oe_o, busy_o}, 64'hE);
    end

    // R1: reset during a read frame
    @(negedge clk);
    reg_addr_i = 8'h44; len_i = 3'd3; rd_i = 1'b1; div_i = 8'd2; dly_i = 3'd1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (60) @(negedge clk);
    chk(busy_o, "R1", "frame running before reset", 64'(busy_o), 64'd1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(scl_o && sda_o && sda_oe_o && !busy_o && !done_o && !err_o && rdata_o == '0,
        "R1", "reset mid-frame", {58'd0, scl_o, sda_o, sda_oe_o, busy_o, done_o, err_o},
        64'h38);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // clean frame after the aborted one, with a start poke (R9)
    run_xfer(8'h96, 2, 1'b1, 8'h00, 8'd3, 3'd3, 64'h0000_0000_0000_C001, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule